// File: doc/BRIEF.md
# Transmit Timestamp Capture Latch

This block records the time at which an outgoing frame that asked for a timestamp begins to leave the MAC. A stub 64-bit time counter advances by a programmable step on every clock. When the transmit path raises its start-of-frame strobe in the same cycle as its per-frame timestamp request, and capture is enabled, the counter value of that cycle is latched. Software can then read the held value as two 32-bit words.

The latch is one-shot. After it captures, a sticky flag shows that a value is held, and every later request is ignored. The latch re-arms only when software reads the upper timestamp word. Software therefore reads the lower word first, then the upper word, and joins them with the upper word shifted left by 32.

A small register port, with a write strobe, a read strobe, an address and 32-bit data, gives access to a control word, the two timestamp words and the counter step.

Top module: `tx_stamp_latch`

## Requirements
- R1: After a synchronous active-high reset, the control word, the low stamp word and the high stamp word all read 0, the time counter is 0 and the step register reads INC_RESET (default 1).
- R2: Bit 4 of the control word (address 0) is the capture-enable bit and can be read and written. While it is 0, no capture occurs.
- R3: A capture requires the request input and the start-of-frame input to be high in the same cycle. A request without a start-of-frame, or a start-of-frame without a request, never captures.
- R4: The time counter adds the step register (address 3, read/write) to its value on every clock. A capture latches the counter value that is present in the cycle of the start-of-frame strobe. A new step takes effect from the cycle after its write.
- R5: Bit 0 of the control word is the read-only valid flag. A capture sets it, and a write to the control word does not change it. All other control bits read 0.
- R6: While the valid flag is set, flagged frames are ignored and the held value is not overwritten.
- R7: A read of the high stamp word (address 2) clears the valid flag and re-arms the latch, and it does so even when the flag is already clear. A read of the low word (address 1) leaves the flag set.
- R8: Clearing the enable bit does not drop a value that is already held.
- R9: If a capture and a high-word read fall in the same cycle while the flag is clear, the capture wins and the flag ends set. If the flag is set, the read releases the latch and the frame is ignored.
- R10: The low word is bits 31:0 of the stamp and the high word is bits 63:32. Unmapped addresses (4 to 7) read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| tx_req_i | input | 1 | Per-frame timestamp request from the transmit path |
| tx_sof_i | input | 1 | Start-of-frame event strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (a read of address 2 releases the latch) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from the address |

## Verification
The bench steps through every combination of enable, request and start-of-frame, both with the latch empty and with it holding a value. This separates the three capture conditions from the locking rule. It then tries several step values, including the full 32-bit step, which pushes carries into the high word. A bit-slice or carry error in the counter or the stamp therefore shows up as a mismatch against an arithmetic model kept in the bench. Directed cases cover the order of low and high reads, disabling while a value is held, writes aimed at the read-only flag, and a capture and a release arriving in the same cycle, with the latch both empty and full.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int unsigned TSL_ADDR_CTRL = 0;
  localparam int unsigned TSL_ADDR_LO   = 1;
  localparam int unsigned TSL_ADDR_HI   = 2;
  localparam int unsigned TSL_ADDR_STEP = 3;
  localparam int unsigned TSL_BIT_VALID = 0;
  localparam int unsigned TSL_BIT_EN    = 4;

  // A capture fires only for a flagged frame, while enabled, into an empty latch
  function automatic logic tsl_fire(input logic req, input logic sof,
                                    input logic en, input logic held);
    return req & sof & en & ~held;
  endfunction
endpackage

// File: rtl/tsl_time_counter.sv
module tsl_time_counter #(
  parameter int unsigned TS_W      = 64,
  parameter int unsigned INC_W     = 32,
  parameter logic [INC_W-1:0] INC_RESET = 1
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             step_wr_i,
  input  logic [INC_W-1:0] step_data_i,
  output logic [INC_W-1:0] step_o,
  output logic [TS_W-1:0]  time_o
);
  logic [TS_W-1:0]  time_q;
  logic [INC_W-1:0] step_q;

  function automatic logic [TS_W-1:0] next_time(input logic [TS_W-1:0] t,
                                                input logic [INC_W-1:0] s);
    return t + TS_W'(s);
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      time_q <= '0;
      step_q <= INC_RESET;
    end else begin
      time_q <= next_time(time_q, step_q);
      if (step_wr_i) step_q <= step_data_i;
    end
  end

  assign time_o = time_q;
  assign step_o = step_q;

  AST_TIME_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> time_q == $past(time_q) + TS_W'($past(step_q))); // R4
  AST_STEP_LOAD: assert property (@(posedge clk_i) disable iff (rst_i)
    step_wr_i |=> step_q == $past(step_data_i)); // R4
endmodule

// File: rtl/tsl_capture.sv
module tsl_capture
  import tsl_pkg::*;
#(
  parameter int unsigned TS_W = 64
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            enable_i,
  input  logic            req_i,
  input  logic            sof_i,
  input  logic            release_i,
  input  logic [TS_W-1:0] time_i,
  output logic            valid_o,
  output logic [TS_W-1:0] stamp_o,
  output logic            fire_o
);
  logic            valid_q;
  logic [TS_W-1:0] stamp_q;
  logic            fire;

  assign fire = tsl_fire(req_i, sof_i, enable_i, valid_q);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q <= 1'b0;
      stamp_q <= '0;
    end else if (fire) begin
      valid_q <= 1'b1;
      stamp_q <= time_i;
    end else if (release_i) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o = valid_q;
  assign stamp_o = stamp_q;
  assign fire_o  = fire;

  AST_CAPTURE_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
    fire |=> valid_q && stamp_q == $past(time_i)); // R4
  AST_NO_FIRE_DISABLED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!enable_i && !valid_q) |=> !valid_q); // R2
  AST_NO_FIRE_UNFLAGGED: assert property (@(posedge clk_i) disable iff (rst_i)
    (!(req_i && sof_i) && !valid_q) |=> !valid_q); // R3
  AST_HOLD_WHILE_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (valid_q && !release_i) |=> valid_q && $stable(stamp_q)); // R6
  AST_STAMP_ONLY_ON_FIRE: assert property (@(posedge clk_i) disable iff (rst_i)
    !fire |=> $stable(stamp_q)); // R6
  AST_RELEASE_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
    (release_i && !fire) |=> !valid_q); // R7
  AST_FIRE_WINS: assert property (@(posedge clk_i) disable iff (rst_i)
    (release_i && fire) |=> valid_q); // R9
endmodule

// File: rtl/tsl_regs.sv
module tsl_regs
  import tsl_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned INC_W  = 32
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic                valid_i,
  input  logic [2*DATA_W-1:0] stamp_i,
  input  logic [INC_W-1:0]    step_i,
  output logic                enable_o,
  output logic                release_o,
  output logic                step_wr_o,
  output logic [INC_W-1:0]    step_data_o
);
  localparam int unsigned TS_W = 2 * DATA_W;

  logic enable_q;
  logic sel_ctrl, sel_lo, sel_hi, sel_step;

  assign sel_ctrl = addr_i == ADDR_W'(TSL_ADDR_CTRL);
  assign sel_lo   = addr_i == ADDR_W'(TSL_ADDR_LO);
  assign sel_hi   = addr_i == ADDR_W'(TSL_ADDR_HI);
  assign sel_step = addr_i == ADDR_W'(TSL_ADDR_STEP);

  function automatic logic [DATA_W-1:0] ctrl_word(input logic v, input logic en);
    logic [DATA_W-1:0] w;
    w = '0;
    w[TSL_BIT_VALID] = v;
    w[TSL_BIT_EN]    = en;
    return w;
  endfunction

  always_ff @(posedge clk_i) begin
    if (rst_i) enable_q <= 1'b0;
    else if (wr_i && sel_ctrl) enable_q <= wdata_i[TSL_BIT_EN];
  end

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = ctrl_word(valid_i, enable_q);
    else if (sel_lo)   rdata_o = stamp_i[DATA_W-1:0];
    else if (sel_hi)   rdata_o = stamp_i[TS_W-1:DATA_W];
    else if (sel_step) rdata_o = DATA_W'(step_i);
  end

  assign enable_o    = enable_q;
  assign release_o   = rd_i && sel_hi;
  assign step_wr_o   = wr_i && sel_step;
  assign step_data_o = wdata_i[INC_W-1:0];

  AST_ENABLE_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    (wr_i && sel_ctrl) |=> enable_q == $past(wdata_i[TSL_BIT_EN])); // R2
  AST_ENABLE_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_i && sel_ctrl) |=> $stable(enable_q)); // R8
endmodule

// File: rtl/tx_stamp_latch.sv
module tx_stamp_latch #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned INC_W     = 32,
  parameter logic [INC_W-1:0] INC_RESET = 1
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              tx_req_i,
  input  logic              tx_sof_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  localparam int unsigned TS_W = 2 * DATA_W;

  logic             enable;
  logic             release_req;
  logic             step_wr;
  logic [INC_W-1:0] step_data;
  logic [INC_W-1:0] step;
  logic [TS_W-1:0]  time_now;
  logic [TS_W-1:0]  stamp;
  logic             valid;
  logic             capture_fire;

  tsl_time_counter #(.TS_W(TS_W), .INC_W(INC_W), .INC_RESET(INC_RESET)) u_ctr (
    .clk_i(clk_i), .rst_i(rst_i), .step_wr_i(step_wr), .step_data_i(step_data),
    .step_o(step), .time_o(time_now)
  );

  tsl_capture #(.TS_W(TS_W)) u_cap (
    .clk_i(clk_i), .rst_i(rst_i), .enable_i(enable), .req_i(tx_req_i),
    .sof_i(tx_sof_i), .release_i(release_req), .time_i(time_now),
    .valid_o(valid), .stamp_o(stamp), .fire_o(capture_fire)
  );

  tsl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INC_W(INC_W)) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .wr_i(reg_wr_i), .rd_i(reg_rd_i),
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .valid_i(valid), .stamp_i(stamp), .step_i(step), .enable_o(enable),
    .release_o(release_req), .step_wr_o(step_wr), .step_data_o(step_data)
  );

  AST_FIRE_NEEDS_EMPTY: assert property (@(posedge clk_i) disable iff (rst_i)
    capture_fire |-> !valid && enable); // R6
  AST_STAMP_ZERO_AFTER_RESET: assert property (@(posedge clk_i)
    $past(rst_i) |-> stamp == '0 && !valid && !enable); // R1
endmodule

// File: tb/tx_stamp_latch_tb.sv
module tx_stamp_latch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tx_req = 1'b0, tx_sof = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [63:0] m_time;
  logic [31:0] m_step;

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_stamp_latch u_dut (
    .clk_i(clk), .rst_i(rst), .tx_req_i(tx_req), .tx_sof_i(tx_sof),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata)
  );

  // Arithmetic model of the counter: +step per clock, new step next cycle
  always @(posedge clk) begin
    if (rst) begin
      m_time <= 64'd0;
      m_step <= 32'd1;
    end else begin
      m_time <= m_time + {32'd0, m_step};
      if (reg_wr && reg_addr == 3'd3) m_step <= reg_wdata;
    end
  end

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic frame(input logic rq, input logic sf, output logic [63:0] t);
    tx_req = rq; tx_sof = sf; t = m_time;
    @(negedge clk);
    tx_req = 1'b0; tx_sof = 1'b0;
  endtask

  task automatic read_stamp(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(3'd1, lo);
    rd(3'd2, hi);
    s = {hi, lo};
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] t, held, s;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd0, d); check(d, 0, "R1 ctrl");
    rd(3'd1, d); check(d, 0, "R1 lo");
    rd(3'd2, d); check(d, 0, "R1 hi");
    rd(3'd3, d); check(d, 1, "R1 step");
    // R10 unmapped addresses
    for (int a = 4; a < 8; a++) begin
      rd(3'(a), d); check(d, 0, "R10 unmapped");
    end

    // R5 write to valid bit has no effect
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); check(d, 32'h10, "R5 ro valid");
    wr(3'd0, 32'h0);

    // Sweep: held state x enable x request x start-of-frame
    for (int pv = 0; pv < 2; pv++)
      for (int en = 0; en < 2; en++)
        for (int rq = 0; rq < 2; rq++)
          for (int sf = 0; sf < 2; sf++) begin
            logic ev;
            logic [63:0] es;
            wr(3'd0, 32'h10);
            rd(3'd2, d);
            held = '0;
            if (pv != 0) frame(1'b1, 1'b1, held);
            wr(3'd0, en != 0 ? 32'h10 : 32'h0);
            frame(rq[0], sf[0], t);
            ev = (pv != 0) || (en != 0 && rq != 0 && sf != 0);
            es = (pv != 0) ? held : t;
            rd(3'd0, d);
            check(d, {27'd0, en[0], 3'd0, ev},
                  pv != 0 ? "R6 ctrl" : (en != 0 ? "R3 ctrl" : "R2 ctrl"));
            if (ev) begin
              rd(3'd1, d); check(d, es[31:0], "R10 lo");
              rd(3'd0, d); check(d[0], 1, "R7 lo read keeps valid");
              rd(3'd2, d); check(d, es[63:32], "R4 hi");
            end else begin
              rd(3'd2, d);
            end
            rd(3'd0, d); check(d[0], 0, "R7 hi read releases");
          end

    // R4 step sweep, including carries into the high word
    begin
      logic [31:0] steps [5] = '{32'd1, 32'd5, 32'h0001_0000, 32'hFFFF_FFFF, 32'h8000_0001};
      wr(3'd0, 32'h10);
      foreach (steps[i]) begin
        wr(3'd3, steps[i]);
        rd(3'd3, d); check(d, steps[i], "R4 step readback");
        repeat (i + 3) @(negedge clk);
        frame(1'b1, 1'b1, t);
        read_stamp(s); check(s, t, "R4 stamp");
      end
    end

    // R8 disabling keeps the held value
    frame(1'b1, 1'b1, t);
    wr(3'd0, 32'h0);
    rd(3'd0, d); check(d, 32'h1, "R8 valid kept");
    wr(3'd0, 32'h1); rd(3'd0, d); check(d, 32'h1, "R5 write keeps valid");
    read_stamp(s); check(s, t, "R8 stamp kept");

    // R9 simultaneous capture and release with latch empty: capture wins
    wr(3'd0, 32'h10);
    reg_rd = 1'b1; reg_addr = 3'd2; tx_req = 1'b1; tx_sof = 1'b1; t = m_time;
    @(negedge clk);
    reg_rd = 1'b0; tx_req = 1'b0; tx_sof = 1'b0;
    rd(3'd0, d); check(d, 32'h11, "R9 empty capture wins");
    rd(3'd1, d); check(d, t[31:0], "R9 stamp lo");
    // with latch full: release wins, frame ignored
    reg_rd = 1'b1; reg_addr = 3'd2; tx_req = 1'b1; tx_sof = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0; tx_req = 1'b0; tx_sof = 1'b0;
    rd(3'd0, d); check(d, 32'h10, "R9 full release wins");
    rd(3'd1, d); check(d, t[31:0], "R9 stamp unchanged");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule